// File: doc/BRIEF.md
# Two-Bit Four-Function ALU

This block is a small combinational arithmetic-logic unit. It takes two 2-bit operands and a 2-bit function code. It returns a 2-bit result and an overflow flag. One function code selects unsigned addition. The other three select logic operations: the inversion of the first operand, bitwise OR and bitwise AND.

All four results are computed in parallel. The adder is a ripple chain of full adders with no carry input. A logic unit forms the three bitwise results. A 4-to-1 multiplexer, steered by the function code, picks the result. The adder's carry out leaves the block as the overflow flag, but only while addition is selected. The block holds no state, so a surrounding pipeline stage registers its outputs.

Top module: `alu2_core`

## Requirements
- R1: With func_i = 2'b00, res_o equals (a_i + b_i) modulo 4.
- R2: With func_i = 2'b00, ovf_o is 1 exactly when the unsigned sum a_i + b_i is 4 or more.
- R3: With func_i equal to 2'b01, 2'b10 or 2'b11, ovf_o is 0 for every pair of operands.
- R4: With func_i = 2'b01, res_o equals the bitwise inverse of a_i, and changing b_i has no effect on res_o.
- R5: With func_i = 2'b10, res_o equals a_i | b_i, bit by bit.
- R6: With func_i = 2'b11, res_o equals a_i & b_i, bit by bit.
- R7: The block is purely combinational. Both outputs follow a change on any input in the same time step, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 2 | First operand |
| b_i | input | 2 | Second operand |
| func_i | input | 2 | Function code: 00 add, 01 invert a_i, 10 OR, 11 AND |
| res_o | output | 2 | Selected result |
| ovf_o | output | 1 | Carry out of the addition, 0 for the logic functions |

## Verification
Two functions can meet in one cycle: the adder's carry out and any logic function. The adder always runs, so operand pairs that overflow are also applied while a logic code is selected. For those pairs the check is that ovf_o stays low while res_o carries the logic result. The full sweep applies every operand pair under every function code. It checks both outputs against sums and bitwise results that the bench computes itself. Separately, each a_i is held while b_i steps through all four values under the invert code, and res_o must not change.

// File: rtl/alu2_pkg.sv
package alu2_pkg;
  localparam int unsigned FUNC_W = 2;

  typedef enum logic [FUNC_W-1:0] {
    OP_ADD = 2'b00,
    OP_INV = 2'b01,
    OP_OR  = 2'b10,
    OP_AND = 2'b11
  } alu_op_e;
endpackage

// File: rtl/alu2_full_add.sv
module alu2_full_add (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic half_x;

  assign half_x = a_i ^ b_i;
  assign s_o    = half_x ^ c_i;
  assign c_o    = (a_i & b_i) | (half_x & c_i);
endmodule

// File: rtl/alu2_ripple_add.sv
module alu2_ripple_add #(
  parameter int unsigned WIDTH = 2
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  logic [WIDTH:0] chain;

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    alu2_full_add u_fa (
      .a_i (a_i[i]),
      .b_i (b_i[i]),
      .c_i (chain[i]),
      .s_o (sum_o[i]),
      .c_o (chain[i+1])
    );
  end

  assign carry_o = chain[WIDTH];
endmodule

// File: rtl/alu2_logic_unit.sv
module alu2_logic_unit #(
  parameter int unsigned WIDTH = 2
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] inv_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] and_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign inv_o[i] = ~a_i[i];
    assign or_o[i]  = a_i[i] | b_i[i];
    assign and_o[i] = a_i[i] & b_i[i];
  end
endmodule

// File: rtl/alu2_result_mux.sv
module alu2_result_mux
  import alu2_pkg::*;
#(
  parameter int unsigned WIDTH = 2
) (
  input  alu_op_e          sel_i,
  input  logic [WIDTH-1:0] add_i,
  input  logic [WIDTH-1:0] inv_i,
  input  logic [WIDTH-1:0] or_i,
  input  logic [WIDTH-1:0] and_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      OP_ADD:  res_o = add_i;
      OP_INV:  res_o = inv_i;
      OP_OR:   res_o = or_i;
      OP_AND:  res_o = and_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu2_core.sv
module alu2_core
  import alu2_pkg::*;
#(
  parameter int unsigned WIDTH = 2
) (
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic [FUNC_W-1:0] func_i,
  output logic [WIDTH-1:0]  res_o,
  output logic              ovf_o
);
  alu_op_e          op;
  logic [WIDTH-1:0] sum;
  logic             carry;
  logic [WIDTH-1:0] inv_r, or_r, and_r;

  assign op = alu_op_e'(func_i);

  alu2_ripple_add #(.WIDTH(WIDTH)) u_add (
    .a_i     (a_i),
    .b_i     (b_i),
    .sum_o   (sum),
    .carry_o (carry)
  );

  alu2_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .inv_o (inv_r),
    .or_o  (or_r),
    .and_o (and_r)
  );

  alu2_result_mux #(.WIDTH(WIDTH)) u_mux (
    .sel_i (op),
    .add_i (sum),
    .inv_i (inv_r),
    .or_i  (or_r),
    .and_i (and_r),
    .res_o (res_o)
  );

  // carry leaves the block only on the add code
  assign ovf_o = carry & (op == OP_ADD);
endmodule

// File: rtl/alu2_core_chk.sv
module alu2_core_chk #(
  parameter int unsigned WIDTH = 2
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [1:0]       func_i,
  input logic [WIDTH-1:0] res_o,
  input logic             ovf_o
);
  logic [WIDTH:0] ref_sum;

  assign ref_sum = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    if (func_i == 2'b00) begin
      AST_ADD_RESULT: assert ({ovf_o, res_o} == ref_sum); // R1 R2
    end
    if (func_i != 2'b00) begin
      AST_NO_OVERFLOW: assert (!ovf_o); // R3
    end
    if (func_i == 2'b01) begin
      AST_INV_RESULT: assert ((res_o ^ a_i) == {WIDTH{1'b1}}); // R4
    end
    if (func_i == 2'b10) begin
      AST_OR_RESULT: assert (((res_o & a_i) == a_i) && ((res_o & b_i) == b_i) && ((res_o & ~(a_i | b_i)) == '0)); // R5
    end
    if (func_i == 2'b11) begin
      AST_AND_RESULT: assert (((res_o & ~a_i) == '0) && ((res_o & ~b_i) == '0) && ((a_i & b_i & ~res_o) == '0)); // R6
    end
  end
endmodule

bind alu2_core alu2_core_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .func_i (func_i),
  .res_o  (res_o),
  .ovf_o  (ovf_o)
);

// File: tb/alu2_core_bench.sv
`timescale 1ns/1ps
module alu2_core_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] a, b, f;
  logic [1:0] res;
  logic       ovf;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  alu2_core u_alu2_core (
    .a_i    (a),
    .b_i    (b),
    .func_i (f),
    .res_o  (res),
    .ovf_o  (ovf)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d f=%0d actual={ovf,res}=%b expected=%b", req, a, b, f, act, exp);
    end
  endtask

  task automatic apply(input int av, input int bv, input int fv);
    @(negedge clk);
    a = av[1:0];
    b = bv[1:0];
    f = fv[1:0];
    #1;
  endtask

  initial begin
    a = '0; b = '0; f = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 idle", {ovf, res}, 3'b000);
    rst_ni = 1'b1;

    // exhaustive sweep
    for (int k = 0; k < 64; k++) begin
      int av, bv, fv, s;
      av = k % 4;
      bv = (k / 4) % 4;
      fv = k / 16;
      apply(av, bv, fv);
      s = av + bv;
      case (fv)
        0: check("R1 R2 add", {ovf, res}, {s >= 4, 2'(s % 4)});
        1: check("R4 R3 invert", {ovf, res}, {1'b0, 2'(3 - av)});
        2: check("R5 R3 or", {ovf, res}, {1'b0, 2'(av | bv)});
        default: check("R6 R3 and", {ovf, res}, {1'b0, 2'(av & bv)});
      endcase
    end

    // overflowing operands under logic codes
    for (int fv = 1; fv < 4; fv++) begin
      apply(3, 3, fv);
      check("R3 ovf low with 3+3", {ovf, 2'b00}, 3'b000);
      apply(2, 2, fv);
      check("R3 ovf low with 2+2", {ovf, 2'b00}, 3'b000);
    end

    // b_i has no effect under invert
    for (int av = 0; av < 4; av++) begin
      for (int bv = 0; bv < 4; bv++) begin
        apply(av, bv, 1);
        check("R4 b ignored", {1'b0, res}, {1'b0, 2'(3 - av)});
      end
    end

    // same-step response without a clock edge
    apply(1, 1, 0);
    a = 2'd3;
    #0.5;
    check("R7 add follows a", {ovf, res}, 3'b100);
    f = 2'b11;
    #0.5;
    check("R7 and follows f", {ovf, res}, 3'b001);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule